// File: doc/BRIEF.md
# Sliding Bit-Pattern Correlator

This block watches a serial bit stream and, after every accepted bit, compares the most recent N bits against a programmable target pattern of length N. The comparison is done in parallel with one XOR per bit position. The number of disagreements is counted and turned into a signed score equal to twice the agreements minus N. A score of +N means the window holds an exact copy of the target. A score of −N means it holds the bitwise inverse. Values between the two measure partial correlation.

A target and its length are loaded while the stream is idle. After that, one bit is presented per cycle with a valid strobe. The block returns a registered score with a validity flag, exact-copy and inverted-copy flags, and a pair of threshold flags driven by a magnitude threshold. Outputs stay quiet until N bits have entered since reset or since the last load, so no score is ever formed from stale or partial window content.

Top module: `bit_correlator`

## Requirements
- R1: Each accepted bit (`bitValid` high) shifts into the window. The newest bit is compared with target bit 0, and the bit accepted k strobes earlier is compared with target bit k. A pattern sent with its bit N−1 first therefore lines up with the target.
- R2: The score equals 2×(agreements) − N in two's complement, `LEN_W+1` bits wide. Only positions below N are counted, and target bits at or above N have no effect.
- R3: `scoreValid` and the other outputs belong to a bit accepted at a clock edge and are present in the cycle that follows that edge. No score is produced without an accepted bit.
- R4: When fewer than N bits have been accepted since reset or since the last load, no score is produced. Whenever `scoreValid` is low, `score` is zero and all flags are low.
- R5: `trueMatch` is high with a valid score exactly when all N positions agree. The score is then +N.
- R6: `invMatch` is high with a valid score exactly when all N positions disagree. The score is then −N.
- R7: With a nonzero threshold T, `detect` is high when score ≥ T and `invDetect` is high when score ≤ −T. A threshold of 0 holds both flags low.
- R8: `loadTarget` captures `targetIn` and the length and restarts the fill count. A bit presented in the same cycle as a load is discarded and is not counted.
- R9: A loaded length of 0 is taken as 1. A length above `MAX_LEN` is taken as `MAX_LEN`.
- R10: Synchronous reset (`rst` high) clears the window, the target and the fill count, sets the length to `MAX_LEN` and leaves all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Serial data bit |
| bitValid | input | 1 | Accept `bitIn` this cycle |
| loadTarget | input | 1 | Load target pattern and length |
| targetIn | input | MAX_LEN | Target pattern, bit 0 pairs with the newest data bit |
| lenIn | input | LEN_W | Target length N (clamped to 1..MAX_LEN) |
| threshold | input | LEN_W | Detection magnitude, 0 disables the threshold flags |
| scoreValid | output | 1 | Score and flags are valid this cycle |
| score | output | LEN_W+1 | Signed correlation score, range −N..+N |
| trueMatch | output | 1 | All N positions agree |
| invMatch | output | 1 | All N positions disagree |
| detect | output | 1 | Score at or above threshold |
| invDetect | output | 1 | Score at or below negated threshold |

## Verification
A wrong window bit or a misplaced tap shows up as a wrong `score` on the first valid output whose window includes the bad position. That happens within N accepted bits of the error. A fill counter that counts wrong appears as `scoreValid` rising too early or too late after a reset or a load, and it shows on the first output that follows. A wrong length mask or a wrong target register breaks the ±N peaks and the threshold flags on every scored bit from then on, so comparing against a model on every clock exposes it within one window length.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;   // capture target
    logic shift;  // accept bitIn into the window
    logic emit;   // produce a scored output this edge
  } corrCtrl_t;

endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitValid,
  input  logic             loadTarget,
  input  logic [LEN_W-1:0] lenIn,
  output logic [LEN_W-1:0] lenCur,
  output corrCtrl_t        ctrl
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] fillCnt;
  logic [LEN_W-1:0] lenClamped;
  logic             filled;

  always_comb begin
    if (lenIn == '0)
      lenClamped = LEN_ONE;
    else if (lenIn > LEN_MAX)
      lenClamped = LEN_MAX;
    else
      lenClamped = lenIn;
  end

  // The bit accepted now completes the window when fillCnt+1 reaches N
  assign filled = (fillCnt + LEN_ONE) >= lenReg;

  always_comb begin
    ctrl.load  = loadTarget;
    ctrl.shift = bitValid && !loadTarget;
    ctrl.emit  = bitValid && !loadTarget && filled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lenReg  <= LEN_MAX;
      fillCnt <= '0;
    end else if (loadTarget) begin
      lenReg  <= lenClamped;
      fillCnt <= '0;
    end else if (bitValid && (fillCnt < lenReg)) begin
      fillCnt <= fillCnt + LEN_ONE;
    end
  end

  assign lenCur = lenReg;

endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import corr_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int SCORE_W = LEN_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  corrCtrl_t                 ctrl,
  input  logic                      bitIn,
  input  logic [MAX_LEN-1:0]        targetIn,
  input  logic [LEN_W-1:0]          lenCur,
  input  logic [LEN_W-1:0]          threshold,
  output logic                      scoreValid,
  output logic signed [SCORE_W-1:0] score,
  output logic                      trueMatch,
  output logic                      invMatch,
  output logic                      detect,
  output logic                      invDetect
);

  logic [MAX_LEN-1:0] winReg;
  logic [MAX_LEN-1:0] tgtReg;
  logic [MAX_LEN-1:0] nextWin;
  logic [MAX_LEN-1:0] lenMask;
  logic [MAX_LEN-1:0] diffBits;
  logic [LEN_W-1:0]   disCount;

  logic signed [SCORE_W-1:0] lenS;
  logic signed [SCORE_W-1:0] disS;
  logic signed [SCORE_W-1:0] thrS;
  logic signed [SCORE_W-1:0] scoreNext;
  logic                      thrOn;

  // Window after accepting bitIn: newest bit lands at position 0
  generate
    if (MAX_LEN > 1) begin : g_shift
      assign nextWin = {winReg[MAX_LEN-2:0], bitIn};
    end else begin : g_single
      assign nextWin = bitIn;
    end
  endgenerate

  // XOR bank with length mask
  generate
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_xor
      assign lenMask[i]  = LEN_W'(i) < lenCur;
      assign diffBits[i] = (nextWin[i] ^ tgtReg[i]) & lenMask[i];
    end
  endgenerate

  // Disagreement count
  always_comb begin
    disCount = '0;
    for (int k = 0; k < MAX_LEN; k++)
      disCount = disCount + LEN_W'(diffBits[k]);
  end

  // score = N - 2*disagreements = 2*agreements - N
  always_comb begin
    lenS      = SCORE_W'(lenCur);
    disS      = SCORE_W'(disCount);
    thrS      = SCORE_W'(threshold);
    scoreNext = lenS - (disS <<< 1);
    thrOn     = threshold != '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winReg     <= '0;
      tgtReg     <= '0;
      scoreValid <= 1'b0;
      score      <= '0;
      trueMatch  <= 1'b0;
      invMatch   <= 1'b0;
      detect     <= 1'b0;
      invDetect  <= 1'b0;
    end else begin
      if (ctrl.load)
        tgtReg <= targetIn;
      if (ctrl.shift)
        winReg <= nextWin;
      scoreValid <= ctrl.emit;
      if (ctrl.emit) begin
        score     <= scoreNext;
        trueMatch <= disCount == '0;
        invMatch  <= disCount == lenCur;
        detect    <= thrOn && (scoreNext >= thrS);
        invDetect <= thrOn && (scoreNext <= -thrS);
      end else begin
        score     <= '0;
        trueMatch <= 1'b0;
        invMatch  <= 1'b0;
        detect    <= 1'b0;
        invDetect <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bit_correlator.sv
module bit_correlator
  import corr_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int SCORE_W = LEN_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bitIn,
  input  logic                      bitValid,
  input  logic                      loadTarget,
  input  logic [MAX_LEN-1:0]        targetIn,
  input  logic [LEN_W-1:0]          lenIn,
  input  logic [LEN_W-1:0]          threshold,
  output logic                      scoreValid,
  output logic signed [SCORE_W-1:0] score,
  output logic                      trueMatch,
  output logic                      invMatch,
  output logic                      detect,
  output logic                      invDetect
);

  corrCtrl_t        ctrl;
  logic [LEN_W-1:0] lenCur;

  corr_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .bitValid   (bitValid),
    .loadTarget (loadTarget),
    .lenIn      (lenIn),
    .lenCur     (lenCur),
    .ctrl       (ctrl)
  );

  corr_datapath #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .SCORE_W(SCORE_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .bitIn      (bitIn),
    .targetIn   (targetIn),
    .lenCur     (lenCur),
    .threshold  (threshold),
    .scoreValid (scoreValid),
    .score      (score),
    .trueMatch  (trueMatch),
    .invMatch   (invMatch),
    .detect     (detect),
    .invDetect  (invDetect)
  );

endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int SCORE_W = LEN_W + 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bitValid,
  input logic                      loadTarget,
  input logic [LEN_W-1:0]          lenCur,
  input logic                      scoreValid,
  input logic signed [SCORE_W-1:0] score,
  input logic                      trueMatch,
  input logic                      invMatch,
  input logic                      detect,
  input logic                      invDetect
);

  logic signed [SCORE_W-1:0] lenS;
  assign lenS = SCORE_W'(lenCur);

  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    scoreValid |-> (score <= lenS) && (score >= -lenS));

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    scoreValid |-> $past(bitValid) && !$past(loadTarget));

  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !scoreValid |-> (score == '0) && !trueMatch && !invMatch && !detect && !invDetect);

  assert_true_peak_R5: assert property (@(posedge clk) disable iff (rst)
    trueMatch |-> scoreValid && (score == lenS));

  assert_inv_peak_R6: assert property (@(posedge clk) disable iff (rst)
    invMatch |-> scoreValid && (score == -lenS));

  assert_detect_pos_R7: assert property (@(posedge clk) disable iff (rst)
    detect |-> (score > 0) && !invDetect);

  assert_detect_neg_R7: assert property (@(posedge clk) disable iff (rst)
    invDetect |-> (score < 0));

  assert_load_mutes_R8: assert property (@(posedge clk) disable iff (rst)
    $past(loadTarget) |-> !scoreValid);

endmodule

bind bit_correlator corr_checker #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .SCORE_W(SCORE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bitValid   (bitValid),
  .loadTarget (loadTarget),
  .lenCur     (lenCur),
  .scoreValid (scoreValid),
  .score      (score),
  .trueMatch  (trueMatch),
  .invMatch   (invMatch),
  .detect     (detect),
  .invDetect  (invDetect)
);

// File: tb/bit_correlator_tb_top.sv
module bit_correlator_tb_top;

  localparam int CLK_P   = 10;
  localparam int MAX_LEN = 32;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int SCORE_W = LEN_W + 1;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic                      bitIn = 1'b0;
  logic                      bitValid = 1'b0;
  logic                      loadTarget = 1'b0;
  logic [MAX_LEN-1:0]        targetIn = '0;
  logic [LEN_W-1:0]          lenIn = '0;
  logic [LEN_W-1:0]          threshold = '0;
  logic                      scoreValid;
  logic signed [SCORE_W-1:0] score;
  logic                      trueMatch, invMatch, detect, invDetect;

  int total = 0;
  int bad = 0;
  bit running = 1'b1;

  // reference model state
  bit q[$];
  int mFill = 0;
  int mLen = MAX_LEN;
  logic [MAX_LEN-1:0] mTgt = '0;
  int eValid = 0, eScore = 0, eTrue = 0, eInv = 0, eDet = 0, eInvDet = 0;

  // observation logs
  int obsScore[$];
  int obsTrue[$];
  int obsInv[$];
  int validSeen = 0;
  int lastScore = 0;

  bit_correlator #(.MAX_LEN(MAX_LEN)) dut_i (
    .clk(clk), .rst(rst), .bitIn(bitIn), .bitValid(bitValid),
    .loadTarget(loadTarget), .targetIn(targetIn), .lenIn(lenIn),
    .threshold(threshold), .scoreValid(scoreValid), .score(score),
    .trueMatch(trueMatch), .invMatch(invMatch), .detect(detect),
    .invDetect(invDetect)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model update at the edge, compare a quarter period later
  always @(posedge clk) begin
    int agr;
    int thr;
    if (rst) begin
      q.delete(); mFill = 0; mLen = MAX_LEN; mTgt = '0; eValid = 0;
    end else if (loadTarget) begin
      mLen = (lenIn == 0) ? 1 : ((int'(lenIn) > MAX_LEN) ? MAX_LEN : int'(lenIn));
      mTgt = targetIn; mFill = 0; eValid = 0;
    end else if (bitValid) begin
      q.push_front(bitIn);
      if (q.size() > MAX_LEN) void'(q.pop_back());
      if (mFill < mLen) mFill++;
      eValid = (mFill >= mLen) ? 1 : 0;
    end else begin
      eValid = 0;
    end
    eScore = 0; eTrue = 0; eInv = 0; eDet = 0; eInvDet = 0;
    if (eValid == 1) begin
      agr = 0;
      for (int k = 0; k < mLen; k++) if (q[k] == mTgt[k]) agr++;
      eScore = 2 * agr - mLen;
      eTrue = (agr == mLen) ? 1 : 0;
      eInv = (agr == 0) ? 1 : 0;
      thr = int'(threshold);
      eDet = (thr != 0 && eScore >= thr) ? 1 : 0;
      eInvDet = (thr != 0 && eScore <= -thr) ? 1 : 0;
    end
    #(CLK_P/4);
    if (running) begin
      chk("R3/R4 scoreValid", int'(scoreValid), eValid);
      chk("R2 score", int'(score), eScore);
      chk("R5 trueMatch", int'(trueMatch), eTrue);
      chk("R6 invMatch", int'(invMatch), eInv);
      chk("R7 detect", int'(detect), eDet);
      chk("R7 invDetect", int'(invDetect), eInvDet);
      if (scoreValid) begin
        validSeen++;
        lastScore = int'(score);
        obsScore.push_back(int'(score));
        obsTrue.push_back(int'(trueMatch));
        obsInv.push_back(int'(invMatch));
      end
    end
  end

  task automatic sendBit(bit b);
    @(negedge clk);
    bitIn = b; bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  // back-to-back bits: leaves bitValid set between calls
  task automatic streamBit(bit b);
    bitIn = b; bitValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic loadPat(logic [MAX_LEN-1:0] t, int len, int thr, bit withBit);
    @(negedge clk);
    loadTarget = 1'b1; targetIn = t; lenIn = LEN_W'(len); threshold = LEN_W'(thr);
    bitValid = withBit; bitIn = 1'b1;
    @(negedge clk);
    loadTarget = 1'b0; bitValid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit stream[10] = '{1,1,1,0,1,0,0,1,0,1};
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk("R10 reset scoreValid", int'(scoreValid), 0);
    chk("R10 reset score", int'(score), 0);
    rst = 1'b0;

    // R1: worked example, target 11010 sent MSB first
    loadPat(MAX_LEN'(5'b11010), 5, 4, 1'b0);
    obsScore.delete(); obsTrue.delete(); obsInv.delete();
    @(negedge clk);
    foreach (stream[i]) streamBit(stream[i]);
    bitValid = 1'b0;
    @(negedge clk);
    chk("R1 offsets scored", obsScore.size(), 6);
    if (obsScore.size() == 6) begin
      chk("R1 offset1 score", obsScore[1], 5);
      chk("R5 offset1 trueMatch", obsTrue[1], 1);
      chk("R1 offset5 score", obsScore[5], -5);
      chk("R6 offset5 invMatch", obsInv[5], 1);
    end

    // R8: bit in the load cycle is discarded
    loadPat(MAX_LEN'(2'b10), 2, 1, 1'b1);
    validSeen = 0;
    sendBit(1'b1);
    chk("R8 no score after one bit", validSeen, 0);
    sendBit(1'b0);
    chk("R8 score after two bits", validSeen, 1);
    chk("R8 target 10 matched", lastScore, 2);

    // R9: length clamping
    loadPat(MAX_LEN'(1), 0, 0, 1'b0);
    validSeen = 0;
    sendBit(1'b0);
    chk("R9 len0 acts as 1 valid", validSeen, 1);
    chk("R9 len0 acts as 1 score", lastScore, -1);
    loadPat('1, 40, 0, 1'b0);
    validSeen = 0;
    for (int i = 0; i < MAX_LEN - 1; i++) sendBit(1'b1);
    chk("R9 len40 not yet full", validSeen, 0);
    sendBit(1'b1);
    chk("R9 len40 clamps to 32", lastScore, MAX_LEN);

    // R2/R7: randomized rounds with injected copies and inverses
    for (int r = 0; r < 40; r++) begin
      int len = 1 + int'($urandom_range(MAX_LEN - 1));
      logic [MAX_LEN-1:0] t = MAX_LEN'({$urandom, $urandom});
      int thr = int'($urandom_range(len));
      loadPat(t, len, thr, 1'b0);
      for (int i = 0; i < 50; i++) begin
        int m = int'($urandom_range(9));
        if (m == 0) begin
          for (int k = len - 1; k >= 0; k--) streamBit(t[k]);
        end else if (m == 1) begin
          for (int k = len - 1; k >= 0; k--) streamBit(~t[k]);
        end else if (m == 2) begin
          bitValid = 1'b0; @(negedge clk);
        end else begin
          streamBit(1'($urandom));
        end
      end
      bitValid = 1'b0;
      if (r == 20) begin
        // R10: mid-stream reset restarts the fill
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        validSeen = 0;
        for (int i = 0; i < MAX_LEN - 1; i++) sendBit(1'b1);
        chk("R10 no score before refill", validSeen, 0);
      end
    end

    repeat (3) @(negedge clk);
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule